// File: doc/BRIEF.md
# Coded Ratio Clock Divider

This block divides a fast input clock by a ratio chosen through a 3-bit select code. The code-to-ratio table is fixed and uneven: the codes give 1, 2, 3, 4, 5, 6, 8 and 10, so there is no divide-by-7 or divide-by-9. Divide-by-1 passes the input clock straight through a bypass path. Every other ratio is produced by a period counter. Even ratios give an exact half duty cycle. Odd ratios are high for one input cycle more than they are low.

The select code is only taken up when the period counter wraps. A code change never cuts a pulse short or leaves a runt on the output. After reset the block runs at divide-by-10.

A parameter chooses the feedback variant. In that variant the two lowest codes are not allowed. If one of them is applied, the block keeps the ratio it was running and raises an error flag. While the active-low reset is held, the output stays low and the counter stays cleared.

Top module: `ratio_clk_div`

## Requirements
- R1: Select code c maps to ratio N as follows: 0→1, 1→2, 2→3, 3→4, 4→5, 5→6, 6→8, 7→10. The output period is N input cycles.
- R2: For an even N, the output is high for N/2 input cycles and low for N/2 input cycles.
- R3: For an odd N greater than 1, the output is high for (N+1)/2 input cycles and low for (N-1)/2 input cycles.
- R4: For N = 1, the output follows the input clock, high in the high phase and low in the low phase.
- R5: After reset the active ratio is 10, whatever the select code is. The first low stretch after reset therefore lasts 5 cycles before any new code takes effect.
- R6: While rst_n is low, clk_out is low in both clock phases and code_error is low.
- R7: A new code is adopted only at the counter wrap. The period already in progress finishes at the old ratio.
- R8: In the feedback variant, codes 0 and 1 are reserved. When one is applied, the previous valid ratio keeps running.
- R9: code_error goes high one input cycle after a reserved code is present and low one cycle after a valid code is present. In the general variant it is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| sel_code | input | 3 | Ratio select code |
| clk_out | output | 1 | Divided clock |
| code_error | output | 1 | High while a reserved code is applied (feedback variant) |

## Verification
Two things can fall in the same input cycle: a code change and a counter wrap. In the feedback variant, a reserved code can also arrive in the cycle where the wrap would load it. The bench changes the code in the middle of a high stretch and checks the run lengths on both sides of the wrap: 5 high and 5 low at the old ratio, then 2 and 2 at the new one. It also holds a reserved code over several wraps. During that time the flag must rise one cycle after the code appears, and the measured high and low runs must still match the ratio that was running before.

// File: rtl/ratio_div_pkg.sv
// ratio_div_pkg: shared widths, the code table and the duty helper for the
// coded ratio divider. Assumes 3-bit codes and ratios of at most 15.
package ratio_div_pkg;
    localparam int CODE_W  = 3;
    localparam int RATIO_W = 4;

    typedef logic [CODE_W-1:0]  code_t;
    typedef logic [RATIO_W-1:0] ratio_t;

    localparam ratio_t RESET_RATIO = ratio_t'(10);

    // Map a select code to its ratio; the top two codes skip to 8 and 10.
    function automatic ratio_t code_to_ratio(input code_t c);
        case (c)
            code_t'(6): return ratio_t'(8);
            code_t'(7): return ratio_t'(10);
            default:    return ratio_t'(c) + ratio_t'(1);
        endcase
    endfunction

    // A code is reserved only in the feedback variant, for codes 0 and 1.
    function automatic logic code_reserved(input code_t c, input bit fb);
        return fb && (c == code_t'(0) || c == code_t'(1));
    endfunction

    // Number of high cycles per period: ceil(N/2).
    function automatic ratio_t high_len(input ratio_t n);
        logic [RATIO_W:0] t;
        t = {1'b0, n} + {{RATIO_W{1'b0}}, 1'b1};
        return t[RATIO_W:1];
    endfunction
endpackage

// File: rtl/ratio_code_decode.sv
// ratio_code_decode: turns the select code into a requested ratio and a
// validity bit, and registers the reserved-code flag. Assumes the code is
// synchronous to clk.
module ratio_code_decode
    import ratio_div_pkg::*;
#(
    parameter bit FEEDBACK_MODE = 1'b0
) (
    input  logic   clk,
    input  logic   rst_n,
    input  code_t  sel_code,
    output ratio_t ratio_req,
    output logic   req_ok,
    output logic   code_error
);
    logic reserved;

    // Combinational table lookup and reserved-code test.
    always_comb begin
        ratio_req = code_to_ratio(sel_code);
        reserved  = code_reserved(sel_code, FEEDBACK_MODE);
        req_ok    = !reserved;
    end

    // Register the error flag one cycle behind the code.
    always_ff @(posedge clk) begin
        if (!rst_n) code_error <= 1'b0;
        else        code_error <= reserved;
    end
endmodule

// File: rtl/ratio_period_ctr.sv
// ratio_period_ctr: counts input cycles within one output period and adopts
// a requested ratio only at the wrap. Assumes ratio_req is 1..15.
module ratio_period_ctr
    import ratio_div_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  ratio_t ratio_req,
    input  logic   req_ok,
    output ratio_t cnt_q,
    output ratio_t ratio_q,
    output ratio_t cnt_nx,
    output ratio_t ratio_nx
);
    logic wrap;

    // Next-state: wrap at ratio-1, take a valid request only there.
    always_comb begin
        wrap     = (cnt_q == ratio_q - ratio_t'(1));
        cnt_nx   = wrap ? '0 : cnt_q + ratio_t'(1);
        ratio_nx = (wrap && req_ok) ? ratio_req : ratio_q;
    end

    // State registers, cleared to count 0 at the default ratio.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ratio_q <= RESET_RATIO;
        end else begin
            cnt_q   <= cnt_nx;
            ratio_q <= ratio_nx;
        end
    end
endmodule

// File: rtl/ratio_wave_gen.sv
// ratio_wave_gen: builds the divided waveform from the next count and ratio,
// and selects the input clock itself for ratio 1. Assumes clk_in is the
// clock that drives the counter.
module ratio_wave_gen
    import ratio_div_pkg::*;
(
    input  logic   clk_in,
    input  logic   rst_n,
    input  ratio_t cnt_nx,
    input  ratio_t ratio_nx,
    output logic   clk_out
);
    logic out_q;
    logic bypass_q;

    // Register the level for the coming cycle and the bypass choice.
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            out_q    <= 1'b0;
            bypass_q <= 1'b0;
        end else begin
            out_q    <= (cnt_nx < high_len(ratio_nx));
            bypass_q <= (ratio_nx == ratio_t'(1));
        end
    end

    // Output select: input clock in bypass, else the counted level.
    always_comb clk_out = bypass_q ? clk_in : out_q;
endmodule

// File: rtl/ratio_clk_div.sv
// ratio_clk_div: top of the coded ratio divider. It joins the decoder, the
// period counter and the wave generator. FEEDBACK_MODE reserves codes 0/1.
module ratio_clk_div
    import ratio_div_pkg::*;
#(
    parameter bit FEEDBACK_MODE = 1'b0
) (
    input  logic       clk_in,
    input  logic       rst_n,
    input  logic [2:0] sel_code,
    output logic       clk_out,
    output logic       code_error
);
    ratio_t ratio_req;
    logic   req_ok;
    ratio_t cnt_q;
    ratio_t ratio_q;
    ratio_t cnt_nx;
    ratio_t ratio_nx;

    ratio_code_decode #(.FEEDBACK_MODE(FEEDBACK_MODE)) dec_i (
        .clk(clk_in), .rst_n(rst_n), .sel_code(sel_code),
        .ratio_req(ratio_req), .req_ok(req_ok), .code_error(code_error)
    );

    ratio_period_ctr ctr_i (
        .clk(clk_in), .rst_n(rst_n), .ratio_req(ratio_req), .req_ok(req_ok),
        .cnt_q(cnt_q), .ratio_q(ratio_q), .cnt_nx(cnt_nx), .ratio_nx(ratio_nx)
    );

    ratio_wave_gen wave_i (
        .clk_in(clk_in), .rst_n(rst_n), .cnt_nx(cnt_nx), .ratio_nx(ratio_nx),
        .clk_out(clk_out)
    );
endmodule

// File: rtl/ratio_clk_div_chk.sv
// ratio_clk_div_chk: property checker bound into every ratio_clk_div.
module ratio_clk_div_chk
    import ratio_div_pkg::*;
#(
    parameter bit FEEDBACK_MODE = 1'b0
) (
    input logic   clk_in,
    input logic   rst_n,
    input code_t  sel_code,
    input logic   code_error,
    input ratio_t cnt_q,
    input ratio_t ratio_q
);
    // R7
    cnt_in_range_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        cnt_q < ratio_q);

    // R7
    ratio_at_wrap_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        ($past(rst_n) && ratio_q != $past(ratio_q)) |->
            ($past(cnt_q) == $past(ratio_q) - ratio_t'(1)));

    // R9
    flag_cause_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        ($past(rst_n) && code_error) |-> code_reserved($past(sel_code), FEEDBACK_MODE));

    generate
        if (FEEDBACK_MODE) begin : g_fb
            // R8
            fb_ratio_legal_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
                ratio_q >= ratio_t'(3));
        end else begin : g_gen
            // R9
            no_flag_general_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
                !code_error);
        end
    endgenerate
endmodule

bind ratio_clk_div ratio_clk_div_chk #(.FEEDBACK_MODE(FEEDBACK_MODE)) chk_i (
    .clk_in(clk_in), .rst_n(rst_n), .sel_code(sel_code),
    .code_error(code_error), .cnt_q(cnt_q), .ratio_q(ratio_q)
);

// File: tb/ratio_clk_div_tb_top.sv
`timescale 1ns/1ps
module ratio_clk_div_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel_g = 3'd2;
    logic [2:0] sel_f = 3'd7;
    logic       out_g, err_g, out_f, err_f;
    int         total = 0;
    int         bad = 0;
    bit         smp [0:63];

    always #2.5 clk = ~clk;

    ratio_clk_div #(.FEEDBACK_MODE(1'b0)) dut_i (
        .clk_in(clk), .rst_n(rst_n), .sel_code(sel_g),
        .clk_out(out_g), .code_error(err_g));
    ratio_clk_div #(.FEEDBACK_MODE(1'b1)) dut_fb_i (
        .clk_in(clk), .rst_n(rst_n), .sel_code(sel_f),
        .clk_out(out_f), .code_error(err_f));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ratio_of(input int c);
        if (c == 6) return 8;
        if (c == 7) return 10;
        return c + 1;
    endfunction

    // sample the chosen output in the high phase of the next cycle
    task automatic tick(input bit fb, output bit v);
        @(posedge clk); #1;
        v = fb ? out_f : out_g;
    endtask

    // advance until a high-phase sample rises; leaves smp[0] = 1
    task automatic sync(input bit fb);
        bit v;
        int guard = 0;
        v = 1'b1;
        while (v && guard < 40) begin tick(fb, v); guard++; end
        while (!v && guard < 80) begin tick(fb, v); guard++; end
        smp[0] = v;
    endtask

    task automatic record(input bit fb, input int from);
        bit v;
        for (int i = from; i < 64; i++) begin tick(fb, v); smp[i] = v; end
    endtask

    function automatic int runlen(input int start);
        int n = 0;
        for (int i = start; i < 64; i++) begin
            if (smp[i] != smp[start]) break;
            n++;
        end
        return n;
    endfunction

    task automatic measure(input bit fb, output int h, output int l);
        sync(fb);
        record(fb, 1);
        h = runlen(0);
        l = runlen(h);
    endtask

    initial begin
        #500000;
        bad++; total++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int h, l, h2, l2, n;
        bit v;
        // R6: reset holds output and flag low in both phases
        repeat (3) begin
            @(posedge clk); #1;
            chk(out_g == 1'b0 && out_f == 1'b0, "R6 out high phase", out_g, 0);
            @(negedge clk); #1;
            chk(out_g == 1'b0 && err_g == 1'b0 && err_f == 1'b0, "R6 out/flag low phase", out_g, 0);
        end
        // R5: default ratio 10, code 2 (ratio 3) adopted only at first wrap
        @(negedge clk); rst_n = 1'b1;
        record(1'b0, 0);
        h = runlen(0); l = runlen(h); h2 = runlen(h + l); l2 = runlen(h + l + h2);
        chk(l == 5, "R5 first low stretch", l, 5);
        chk(h2 == 2 && l2 == 1, "R3 ratio 3 after wrap", h2 * 10 + l2, 21);

        // R1/R2/R3: sweep codes 1..7 on the general variant
        for (int c = 1; c < 8; c++) begin
            sel_g = 3'(c);
            repeat (25) @(posedge clk);
            measure(1'b0, h, l);
            n = ratio_of(c);
            chk(h + l == n, "R1 period", h + l, n);
            if (n % 2 == 0) chk(h == n / 2 && l == n / 2, "R2 even duty", h, n / 2);
            else            chk(h == (n + 1) / 2 && l == (n - 1) / 2, "R3 odd duty", h, (n + 1) / 2);
            chk(err_g == 1'b0, "R9 general flag", err_g, 0);
        end

        // R4: code 0 bypasses the input clock
        sel_g = 3'd0;
        repeat (25) @(posedge clk);
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #1;
            chk(out_g == 1'b1, "R4 bypass high phase", out_g, 1);
            @(negedge clk); #1;
            chk(out_g == 1'b0, "R4 bypass low phase", out_g, 0);
        end
        chk(err_g == 1'b0, "R9 general flag code 0", err_g, 0);

        // R7: code change mid-high completes the ratio-10 period first
        sel_g = 3'd7;
        repeat (30) @(posedge clk);
        sync(1'b0);
        tick(1'b0, v); smp[1] = v;
        sel_g = 3'd3;
        record(1'b0, 2);
        h = runlen(0); l = runlen(h); h2 = runlen(h + l); l2 = runlen(h + l + h2);
        chk(h == 5 && l == 5, "R7 old period kept", h * 10 + l, 55);
        chk(h2 == 2 && l2 == 2, "R7 new ratio after wrap", h2 * 10 + l2, 22);

        // R8/R9: feedback variant with reserved codes
        sel_f = 3'd3;
        repeat (25) @(posedge clk);
        measure(1'b1, h, l);
        chk(h == 2 && l == 2 && err_f == 1'b0, "R8 fb ratio 4", h * 10 + l, 22);
        for (int c = 0; c < 2; c++) begin
            @(negedge clk); sel_f = 3'(c);
            @(posedge clk); #1;
            chk(err_f == 1'b1, "R9 flag after reserved code", err_f, 1);
            repeat (25) @(posedge clk);
            measure(1'b1, h, l);
            chk(h == 2 && l == 2, "R8 reserved code keeps ratio", h * 10 + l, 22);
            chk(err_f == 1'b1, "R9 flag held", err_f, 1);
        end
        @(negedge clk); sel_f = 3'd2;
        @(posedge clk); #1;
        chk(err_f == 1'b0, "R9 flag clears", err_f, 0);
        repeat (25) @(posedge clk);
        measure(1'b1, h, l);
        chk(h == 2 && l == 1, "R8 fb ratio 3 after reserved", h * 10 + l, 21);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule